// File: doc/BRIEF.md
# Synthesizer Divider and Reference Selector

This block is the digital divider stage of a frequency synthesizer. It counts pulses from the local-oscillator input and emits one divided pulse each time the effective divide ratio has been reached. In parallel, it divides a 75 kHz crystal tick down to the comparison reference frequency chosen by a 4-bit code. Both pulse trains go to a phase comparator that lies outside this block.

The effective oscillator ratio depends on the input mode:
- In high-band mode the programmed 16-bit value is doubled.
- In low-band fine mode the value is used as it is.
- In low-band coarse mode only the upper twelve bits count.

Values under a mode's minimum are raised to that minimum. Two reference codes put the loop into an inhibit state. In that state both dividers stop and the charge-pump drive is flagged high-impedance. One of the two codes also requests that the crystal oscillator stop. A separate forced-low control overrides the charge-pump state.

Both oscillator and crystal inputs are single-cycle enable ticks in the system clock domain. When a divider's ratio changes, that divider restarts its count.

Top module: `syn_divref_top`

## Requirements
- R1: With `band_hi`=1, one `lo_div_pulse` is produced per 2×`div_value` oscillator ticks.
- R2: With `band_hi`=0 and `range_hi`=1, one `lo_div_pulse` is produced per `div_value` ticks.
- R3: With `band_hi`=0 and `range_hi`=0, the ratio is `div_value[15:4]`. Bits 3:0 have no effect on the pulse count.
- R4: Values below the minimum are clamped: to 272 in the R1/R2 modes, and to 4 in the R3 mode.
- R5: `ref_code` 0–3 divide `xtal_tick` by 3, code 4 by 6, code 5 by 12, and codes 6–7 by 24.
- R6: Codes 8–10 divide by 15, code 11 by 75, code 12 by 25 and code 13 by 5.
- R7: Codes 14 and 15 set `loop_inhibit`. Only code 14 also sets `xtal_stop`. All other codes clear both.
- R8: While inhibited, neither `lo_div_pulse` nor `ref_pulse` occurs, and `cp_hiz` is 1 unless forced low.
- R9: `cp_force_low`=1 gives `cp_low`=1 and `cp_hiz`=0, whatever the inhibit state.
- R10: A change of a divider's effective ratio restarts that divider's count from zero.
- R11: Each output pulse lasts one cycle and appears in the cycle after the clock edge that samples the completing tick.
- R12: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| lo_tick | input | 1 | Oscillator input event, one cycle per edge |
| xtal_tick | input | 1 | Crystal event at 75 kHz, one cycle per edge |
| div_value | input | 16 | Programmed divide value |
| band_hi | input | 1 | 1 selects the high-band (doubled) mode |
| range_hi | input | 1 | In low band: 1 selects the full 16-bit value, 0 the coarse 12-bit value |
| ref_code | input | 4 | Reference select code |
| cp_force_low | input | 1 | Forces the charge-pump drive low |
| lo_div_pulse | output | 1 | Divided oscillator pulse |
| ref_pulse | output | 1 | Reference pulse |
| loop_inhibit | output | 1 | Loop inhibit state |
| xtal_stop | output | 1 | Crystal oscillator stop request |
| cp_hiz | output | 1 | Charge-pump drive high-impedance |
| cp_low | output | 1 | Charge-pump drive forced low |

## Verification
The bench targets the following corner cases:
- **Clamping.** Values just under each mode's minimum are applied. A design without the clamp would divide by the raw value and produce too many pulses.
- **Ignored nibble.** Coarse-mode values are applied with the low nibble set. A design that kept those bits would divide by a much larger ratio.
- **Tick counts one short of a full period.** These expose a divider that fires on the Nth−1 tick.
- **Ratio switch mid-count.** The reference code is changed part way through a count. A divider that did not reload would overshoot its new terminal count and wrap, giving no pulse.
- **Inhibit and forced-low.** These are driven together, to catch a wrong priority between the two charge-pump states.

// File: rtl/syn_div_pkg.sv
package syn_div_pkg;

  typedef enum logic [1:0] {
    MODE_DOUBLE = 2'd0,
    MODE_DIRECT = 2'd1,
    MODE_COARSE = 2'd2
  } lo_mode_e;

  localparam int MIN_FULL     = 272;
  localparam int MIN_COARSE   = 4;
  localparam int COARSE_SHIFT = 4;

  // Reference frequency in Hz per select code; 0 marks an inhibit code.
  function automatic int ref_freq_hz(input int code);
    case (code)
      0, 1, 2, 3: return 25000;
      4:          return 12500;
      5:          return 6250;
      6, 7:       return 3125;
      8, 9, 10:   return 5000;
      11:         return 1000;
      12:         return 3000;
      13:         return 15000;
      default:    return 0;
    endcase
  endfunction

endpackage

// File: rtl/syn_lo_ratio.sv
module syn_lo_ratio
  import syn_div_pkg::*;
#(
  parameter int VAL_W = 16,
  localparam int CNT_W = VAL_W + 1,
  localparam int CRS_W = VAL_W - COARSE_SHIFT
) (
  input  logic [VAL_W-1:0] value,
  input  logic             band_hi,
  input  logic             range_hi,
  output logic [CNT_W-1:0] ratio
);

  lo_mode_e         mode;
  logic [VAL_W-1:0] full_cl;
  logic [CRS_W-1:0] coarse;
  logic [CRS_W-1:0] coarse_cl;

  always_comb begin
    if (band_hi)       mode = MODE_DOUBLE;
    else if (range_hi) mode = MODE_DIRECT;
    else               mode = MODE_COARSE;
  end

  always_comb begin
    coarse    = value[VAL_W-1:COARSE_SHIFT];
    full_cl   = (value < VAL_W'(MIN_FULL)) ? VAL_W'(MIN_FULL) : value;
    coarse_cl = (coarse < CRS_W'(MIN_COARSE)) ? CRS_W'(MIN_COARSE) : coarse;
    case (mode)
      MODE_DOUBLE: ratio = {full_cl, 1'b0};
      MODE_DIRECT: ratio = {1'b0, full_cl};
      default:     ratio = CNT_W'(coarse_cl);
    endcase
  end

endmodule

// File: rtl/syn_ref_select.sv
module syn_ref_select
  import syn_div_pkg::*;
#(
  parameter int XTAL_HZ = 75000,
  parameter int CODE_W  = 4,
  parameter int REF_W   = 7,
  localparam int NCODES = 1 << CODE_W
) (
  input  logic [CODE_W-1:0] code,
  output logic [REF_W-1:0]  ratio,
  output logic              inhibit,
  output logic              osc_stop
);

  logic [REF_W-1:0] ratio_tab [NCODES];

  for (genvar g = 0; g < NCODES; g++) begin : g_tab
    localparam int FHZ = ref_freq_hz(g);
    localparam int RAT = (FHZ == 0) ? 0 : XTAL_HZ / ((FHZ == 0) ? 1 : FHZ);
    assign ratio_tab[g] = REF_W'(RAT);
  end

  always_comb begin
    ratio    = ratio_tab[code];
    inhibit  = (ratio == '0);
    osc_stop = (code == CODE_W'(NCODES - 2));
  end

endmodule

// File: rtl/syn_pulse_div.sv
module syn_pulse_div #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] ratio,
  output logic             pulse
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] ratio_q;
  logic             last;

  assign last = (cnt == ratio_q - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      ratio_q <= '0;
      pulse   <= 1'b0;
    end else begin
      ratio_q <= ratio;
      if (!run || (ratio != ratio_q)) begin
        cnt   <= '0;
        pulse <= 1'b0;
      end else if (tick) begin
        pulse <= last;
        cnt   <= last ? '0 : cnt + CNT_W'(1);
      end else begin
        pulse <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/syn_divref_top.sv
module syn_divref_top #(
  parameter int VAL_W   = 16,
  parameter int CODE_W  = 4,
  parameter int XTAL_HZ = 75000,
  localparam int CNT_W  = VAL_W + 1,
  localparam int REF_W  = $clog2(XTAL_HZ / 1000 + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lo_tick,
  input  logic              xtal_tick,
  input  logic [VAL_W-1:0]  div_value,
  input  logic              band_hi,
  input  logic              range_hi,
  input  logic [CODE_W-1:0] ref_code,
  input  logic              cp_force_low,
  output logic              lo_div_pulse,
  output logic              ref_pulse,
  output logic              loop_inhibit,
  output logic              xtal_stop,
  output logic              cp_hiz,
  output logic              cp_low
);

  logic [CNT_W-1:0] lo_ratio;
  logic [REF_W-1:0] ref_ratio;
  logic             inh;
  logic             ostop;

  syn_lo_ratio #(.VAL_W(VAL_W)) lo_ratio_i (
    .value    (div_value),
    .band_hi  (band_hi),
    .range_hi (range_hi),
    .ratio    (lo_ratio)
  );

  syn_ref_select #(.XTAL_HZ(XTAL_HZ), .CODE_W(CODE_W), .REF_W(REF_W)) ref_sel_i (
    .code     (ref_code),
    .ratio    (ref_ratio),
    .inhibit  (inh),
    .osc_stop (ostop)
  );

  syn_pulse_div #(.CNT_W(CNT_W)) lo_div_i (
    .clk   (clk),
    .rst   (rst),
    .run   (~inh),
    .tick  (lo_tick),
    .ratio (lo_ratio),
    .pulse (lo_div_pulse)
  );

  syn_pulse_div #(.CNT_W(REF_W)) ref_div_i (
    .clk   (clk),
    .rst   (rst),
    .run   (~inh),
    .tick  (xtal_tick),
    .ratio (ref_ratio),
    .pulse (ref_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      loop_inhibit <= 1'b0;
      xtal_stop    <= 1'b0;
      cp_hiz       <= 1'b0;
      cp_low       <= 1'b0;
    end else begin
      loop_inhibit <= inh;
      xtal_stop    <= ostop;
      cp_low       <= cp_force_low;
      cp_hiz       <= inh & ~cp_force_low;
    end
  end

endmodule

// File: rtl/syn_divref_chk.sv
module syn_divref_chk #(
  parameter int VAL_W  = 16,
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              lo_tick,
  input logic              xtal_tick,
  input logic [VAL_W-1:0]  div_value,
  input logic              band_hi,
  input logic              range_hi,
  input logic [CODE_W-1:0] ref_code,
  input logic              cp_force_low,
  input logic              lo_div_pulse,
  input logic              ref_pulse,
  input logic              loop_inhibit,
  input logic              xtal_stop,
  input logic              cp_hiz,
  input logic              cp_low
);

  // R11
  lo_single_chk: assert property (@(posedge clk) disable iff (rst)
    lo_div_pulse |=> !lo_div_pulse);

  // R11
  ref_single_chk: assert property (@(posedge clk) disable iff (rst)
    ref_pulse |=> !ref_pulse);

  // R11
  lo_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
    lo_div_pulse |-> $past(lo_tick));

  // R11
  ref_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
    ref_pulse |-> $past(xtal_tick));

  // R8
  inhibit_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    loop_inhibit |-> (!lo_div_pulse && !ref_pulse));

  // R7
  stop_implies_inhibit_chk: assert property (@(posedge clk) disable iff (rst)
    xtal_stop |-> loop_inhibit);

  // R9
  force_low_excl_chk: assert property (@(posedge clk) disable iff (rst)
    cp_low |-> !cp_hiz);

  // R9
  force_low_follow_chk: assert property (@(posedge clk) disable iff (rst)
    cp_force_low |=> cp_low);

endmodule

bind syn_divref_top syn_divref_chk #(.VAL_W(VAL_W), .CODE_W(CODE_W)) chk_i (.*);

// File: tb/syn_divref_top_tb_top.sv
`timescale 1ns/1ps
module syn_divref_top_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lo_tick = 1'b0;
  logic        xtal_tick = 1'b0;
  logic [15:0] div_value = '0;
  logic        band_hi = 1'b0;
  logic        range_hi = 1'b0;
  logic [3:0]  ref_code = '0;
  logic        cp_force_low = 1'b0;
  logic        lo_div_pulse, ref_pulse, loop_inhibit, xtal_stop, cp_hiz, cp_low;

  int total = 0;
  int bad = 0;
  int lo_seen = 0;
  int ref_seen = 0;

  always #2 clk = ~clk;

  syn_divref_top dut_i (
    .clk(clk), .rst(rst), .lo_tick(lo_tick), .xtal_tick(xtal_tick),
    .div_value(div_value), .band_hi(band_hi), .range_hi(range_hi),
    .ref_code(ref_code), .cp_force_low(cp_force_low),
    .lo_div_pulse(lo_div_pulse), .ref_pulse(ref_pulse),
    .loop_inhibit(loop_inhibit), .xtal_stop(xtal_stop),
    .cp_hiz(cp_hiz), .cp_low(cp_low)
  );

  always @(posedge clk) begin
    if (lo_div_pulse) lo_seen++;
    if (ref_pulse) ref_seen++;
  end

  typedef struct packed {
    logic        is_ref;
    logic        bh;
    logic        rh;
    logic [15:0] val;
    logic [3:0]  code;
    logic [15:0] ticks;
    logic [3:0]  exp;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 1'b0, 16'd300,    4'd0,  16'd1800, 4'd3}, // R1
    '{1'b0, 1'b1, 1'b0, 16'd10,     4'd0,  16'd1088, 4'd2}, // R4 R1
    '{1'b0, 1'b1, 1'b0, 16'd10,     4'd0,  16'd1087, 4'd1}, // R4 R1
    '{1'b0, 1'b0, 1'b1, 16'd272,    4'd0,  16'd816,  4'd3}, // R2
    '{1'b0, 1'b0, 1'b1, 16'd100,    4'd0,  16'd545,  4'd2}, // R4 R2
    '{1'b0, 1'b0, 1'b1, 16'd400,    4'd0,  16'd799,  4'd1}, // R2
    '{1'b0, 1'b0, 1'b0, 16'h0050,   4'd0,  16'd15,   4'd3}, // R3
    '{1'b0, 1'b0, 1'b0, 16'h005F,   4'd0,  16'd14,   4'd2}, // R3
    '{1'b0, 1'b0, 1'b0, 16'h0010,   4'd0,  16'd12,   4'd3}, // R4 R3
    '{1'b1, 1'b0, 1'b0, 16'd0,      4'd0,  16'd6,    4'd2}, // R5
    '{1'b1, 1'b0, 1'b0, 16'd0,      4'd1,  16'd6,    4'd2}, // R5
    '{1'b1, 1'b0, 1'b0, 16'd0,      4'd2,  16'd6,    4'd2}, // R5
    '{1'b1, 1'b0, 1'b0, 16'd0,      4'd3,  16'd5,    4'd1}, // R5
    '{1'b1, 1'b0, 1'b0, 16'd0,      4'd4,  16'd12,   4'd2}, // R5
    '{1'b1, 1'b0, 1'b0, 16'd0,      4'd5,  16'd24,   4'd2}, // R5
    '{1'b1, 1'b0, 1'b0, 16'd0,      4'd6,  16'd48,   4'd2}, // R5
    '{1'b1, 1'b0, 1'b0, 16'd0,      4'd7,  16'd47,   4'd1}, // R5
    '{1'b1, 1'b0, 1'b0, 16'd0,      4'd8,  16'd30,   4'd2}, // R6
    '{1'b1, 1'b0, 1'b0, 16'd0,      4'd9,  16'd30,   4'd2}, // R6
    '{1'b1, 1'b0, 1'b0, 16'd0,      4'd10, 16'd29,   4'd1}, // R6
    '{1'b1, 1'b0, 1'b0, 16'd0,      4'd11, 16'd150,  4'd2}, // R6
    '{1'b1, 1'b0, 1'b0, 16'd0,      4'd12, 16'd50,   4'd2}, // R6
    '{1'b1, 1'b0, 1'b0, 16'd0,      4'd13, 16'd10,   4'd2}, // R6
    '{1'b1, 1'b0, 1'b0, 16'd0,      4'd14, 16'd20,   4'd0}, // R8
    '{1'b1, 1'b0, 1'b0, 16'd0,      4'd15, 16'd20,   4'd0}  // R8
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_lo(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) lo_tick = 1'b1;
      @(negedge clk) lo_tick = 1'b0;
    end
  endtask

  task automatic pulse_ref(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) xtal_tick = 1'b1;
      @(negedge clk) xtal_tick = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int c0;
    settle(3);
    // R12 reset state
    check("R12 lo_div_pulse", lo_div_pulse, 0);
    check("R12 ref_pulse", ref_pulse, 0);
    check("R12 loop_inhibit", loop_inhibit, 0);
    check("R12 cp_hiz/cp_low", {cp_hiz, cp_low}, 0);
    rst = 1'b0;
    settle(2);

    for (int v = 0; v < NV; v++) begin
      band_hi   = VECS[v].bh;
      range_hi  = VECS[v].rh;
      div_value = VECS[v].val;
      ref_code  = VECS[v].code;
      settle(3);
      if (VECS[v].is_ref) begin
        c0 = ref_seen;
        pulse_ref(int'(VECS[v].ticks));
        settle(3);
        check($sformatf("R5/R6/R8 ref vector %0d", v), ref_seen - c0, int'(VECS[v].exp));
      end else begin
        c0 = lo_seen;
        pulse_lo(int'(VECS[v].ticks));
        settle(3);
        check($sformatf("R1-R4 lo vector %0d", v), lo_seen - c0, int'(VECS[v].exp));
      end
    end

    // R7 inhibit codes
    ref_code = 4'd14;
    settle(2);
    check("R7 code14 inhibit", loop_inhibit, 1);
    check("R7 code14 xtal_stop", xtal_stop, 1);
    check("R8 code14 cp_hiz", cp_hiz, 1);
    ref_code = 4'd15;
    settle(2);
    check("R7 code15 inhibit", loop_inhibit, 1);
    check("R7 code15 xtal_stop", xtal_stop, 0);
    ref_code = 4'd13;
    settle(2);
    check("R7 code13 inhibit", loop_inhibit, 0);

    // R8 oscillator divider silent while inhibited
    band_hi = 1'b0; range_hi = 1'b0; div_value = 16'h0040;
    ref_code = 4'd15;
    settle(3);
    c0 = lo_seen;
    pulse_lo(20);
    settle(3);
    check("R8 lo pulses while inhibited", lo_seen - c0, 0);

    // R9 forced low overrides inhibit
    cp_force_low = 1'b1;
    settle(2);
    check("R9 cp_low", cp_low, 1);
    check("R9 cp_hiz", cp_hiz, 0);
    cp_force_low = 1'b0;
    settle(2);
    check("R9 release cp_low", cp_low, 0);
    check("R8 cp_hiz after release", cp_hiz, 1);

    // R10 reload when ratio changes mid-count
    ref_code = 4'd13;
    settle(3);
    c0 = ref_seen;
    pulse_ref(4);
    ref_code = 4'd0;
    settle(3);
    pulse_ref(3);
    settle(3);
    check("R10 ref reload", ref_seen - c0, 1);
    div_value = 16'h0060;
    settle(3);
    c0 = lo_seen;
    pulse_lo(5);
    div_value = 16'h0040;
    settle(3);
    pulse_lo(4);
    settle(3);
    check("R10 lo reload", lo_seen - c0, 1);

    // R11 pulse timing with ratio 3
    ref_code = 4'd0;
    settle(3);
    pulse_ref(2);
    @(negedge clk) xtal_tick = 1'b1;
    @(negedge clk);
    check("R11 ref pulse after third tick", ref_pulse, 1);
    xtal_tick = 1'b0;
    @(negedge clk);
    check("R11 ref pulse one cycle", ref_pulse, 0);

    settle(2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule